// File: doc/BRIEF.md
# Regression Timestamp Frequency Counter

This block estimates the period of a digital input by timestamping each of its rising edges against a free-running count of the fast core clock. It does not count edges inside a fixed window. While a gate is open, every rising edge of the input produces a record made of a running event number x and the clock count y at that edge. The record goes out on a one-cycle capture stream and is stored in a small buffer that can be read back by address.

For each capture, the block also adds five running sums to its accumulators: the count N, Σx, Σy, Σx·y and Σx². The slope of the least-squares line of y against x is (N·Σxy − Σx·Σy) / (N·Σx² − (Σx)²). That slope is the input period in clock cycles, and software can compute it after the gate closes without reading the buffer at all. The input is taken through a synchronizer chain and an edge detector, so it can be asynchronous to the clock.

A new gate clears every accumulator, the event number, the buffer fill level and the overflow flag. It also restarts the time counter. Closing the gate raises a one-cycle done pulse once the final capture has been included in the sums.

Top module: `tsfreq_regress`

## Requirements
- R1: After reset, all outputs are zero: cap_valid, cap_index, cap_time, buf_count, overflow, done and the five sums.
- R2: Each rising edge of sig_in inside an open gate produces exactly one capture. cap_valid is high for one cycle only, and an input held high for many cycles still counts once.
- R3: Let G be the clock edge that first samples gate high and S the edge that first samples sig_in high. The captured cap_time is S − G + 1, and cap_valid appears after edge S+2 (default two synchronizer stages).
- R4: cap_index is 0 for the first capture of a gate and rises by one with each further capture.
- R5: sum_n, sum_x, sum_y, sum_xy and sum_xx equal N, Σx, Σy, Σx·y and Σx² taken over all captures of the current gate, where x is cap_index and y is cap_time.
- R6: A rising gate clears the sums, the event index, buf_count and overflow, and restarts the time counter at zero.
- R7: Rising edges of sig_in while the gate is closed produce no capture and leave every sum unchanged.
- R8: done is high for exactly the one cycle after the edge that first samples gate low. At that point the sums include a capture made on that same edge.
- R9: The first DEPTH records of a gate are stored at addresses 0 to DEPTH−1 in capture order. rd_index and rd_time combinationally show the record at rd_addr, and buf_count gives the number stored.
- R10: Once DEPTH records are stored, further records are dropped, overflow is set and stays set until the next gate, and the sums keep accumulating every capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast time-base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sig_in | input | 1 | Asynchronous input whose period is measured |
| gate | input | 1 | Measurement window; the rising level starts a gate, the falling level ends it |
| rd_addr | input | $clog2(DEPTH) | Buffer read address |
| cap_valid | output | 1 | One-cycle strobe for a new record |
| cap_index | output | TS_W | Event number of the record |
| cap_time | output | TS_W | Timestamp of the record |
| rd_index | output | TS_W | Event number stored at rd_addr |
| rd_time | output | TS_W | Timestamp stored at rd_addr |
| buf_count | output | $clog2(DEPTH+1) | Records stored in the current gate |
| overflow | output | 1 | A record was dropped because the buffer was full |
| done | output | 1 | One-cycle pulse after the gate closes |
| sum_n | output | TS_W | Capture count N |
| sum_x | output | 2*TS_W | Σx |
| sum_y | output | 2*TS_W | Σy |
| sum_xy | output | 3*TS_W | Σx·y |
| sum_xx | output | 3*TS_W | Σx² |

## Verification
The bench sweeps gates with two to eleven pulses, each with a different mix of high and low widths. The sweep includes one-cycle spacing, a pulse starting one cycle after the gate opens, and enough pulses to run past the buffer depth. A latency or count-start error shows up as a timestamp that is off by one against the S − G + 1 rule, and that wrong value spreads into Σy and Σxy. A failed clear on a new gate leaves N or the overflow flag carrying over from the previous gate. If the sums stopped accumulating on overflow, N would freeze at DEPTH. A held-high input and pulses sent while the gate is closed show whether the edge detector retriggers or the gating leaks. A done pulse that is misplaced or too long is caught by sampling it on the cycle after the close and again on the cycle after that.

// File: rtl/tsr_pkg.sv
// Shared types for the regression timestamp counter.
// Assumes nothing beyond a single clock domain for every consumer.
package tsr_pkg;

    // Gate phase decode shared by the timebase and the top level.
    typedef struct packed {
        logic start;   // first edge that samples gate high
        logic stop;    // first edge that samples gate low
        logic open;    // gate window active (registered)
    } gate_ctl_t;

endpackage

// File: rtl/tsr_sync_edge.sv
// Synchronizes an asynchronous input through STAGES flops and flags its
// rising edge for one cycle.
// Assumes STAGES >= 2; the input may change at any time.
module tsr_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] chain;

    // First stage samples the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= async_in;
    end

    // Remaining stages, plus one extra history flop for edge detection.
    for (genvar i = 1; i <= STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
        end
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];

    assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/tsr_timebase.sv
// Registers the gate level, decodes start/stop and runs the time counter,
// which restarts at zero on every gate start.
// Assumes a gate shorter than 2**TS_W cycles so the count never wraps in it.
module tsr_timebase
    import tsr_pkg::*;
#(
    parameter int TS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            gate,
    output gate_ctl_t       ctl,
    output logic [TS_W-1:0] tcount
);
    logic open_q;

    // Remember the gate level of the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) open_q <= 1'b0;
        else        open_q <= gate;
    end

    assign ctl.start = gate & ~open_q;
    assign ctl.stop  = ~gate & open_q;
    assign ctl.open  = open_q;

    // Free-running time count, zeroed when a gate opens.
    always_ff @(posedge clk) begin
        if (!rst_n || ctl.start) tcount <= '0;
        else                     tcount <= tcount + 1'b1;
    end

    assert_count_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.start |=> tcount == $past(tcount) + 1'b1);

    assert_start_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.start |=> tcount == '0);

endmodule

// File: rtl/tsr_accum.sv
// Accumulates N, sum x, sum y, sum x*y and sum x^2 for a least-squares fit.
// Assumes x, y < 2**TS_W and at most 2**TS_W - 1 additions per clear, so the
// derived widths cannot overflow.
module tsr_accum #(
    parameter int TS_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              add,
    input  logic [TS_W-1:0]   x,
    input  logic [TS_W-1:0]   y,
    output logic [TS_W-1:0]   s_n,
    output logic [2*TS_W-1:0] s_x,
    output logic [2*TS_W-1:0] s_y,
    output logic [3*TS_W-1:0] s_xy,
    output logic [3*TS_W-1:0] s_xx
);
    localparam int PW = 2 * TS_W;
    localparam int QW = 3 * TS_W;

    logic [PW-1:0] prod_xy, prod_xx;

    assign prod_xy = PW'(x) * PW'(y);
    assign prod_xx = PW'(x) * PW'(x);

    // Clear on gate start, otherwise add one point per capture.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            s_n  <= '0;
            s_x  <= '0;
            s_y  <= '0;
            s_xy <= '0;
            s_xx <= '0;
        end else if (add) begin
            s_n  <= s_n + 1'b1;
            s_x  <= s_x + PW'(x);
            s_y  <= s_y + PW'(y);
            s_xy <= s_xy + QW'(prod_xy);
            s_xx <= s_xx + QW'(prod_xx);
        end
    end

    assert_n_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (add && !clr) |=> s_n == $past(s_n) + 1'b1);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!add && !clr) |=> $stable(s_y) && $stable(s_n));

endmodule

// File: rtl/tsr_capbuf.sv
// Stores up to DEPTH (index, timestamp) records in capture order, with an
// asynchronous read port. Once full, it drops new records and flags overflow.
// Assumes DEPTH >= 2.
module tsr_capbuf #(
    parameter int TS_W  = 16,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       wr,
    input  logic [TS_W-1:0]            wr_index,
    input  logic [TS_W-1:0]            wr_time,
    input  logic [$clog2(DEPTH)-1:0]   rd_addr,
    output logic [TS_W-1:0]            rd_index,
    output logic [TS_W-1:0]            rd_time,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       ovf
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [TS_W-1:0] mem_idx [DEPTH];
    logic [TS_W-1:0] mem_ts  [DEPTH];
    logic            full;

    assign full = (count == CW'(DEPTH));

    // Fill pointer and sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
            ovf   <= 1'b0;
        end else if (wr) begin
            if (full) ovf   <= 1'b1;
            else      count <= count + 1'b1;
        end
    end

    // Record storage; not reset, since only filled slots are meaningful.
    always_ff @(posedge clk) begin
        if (wr && !full && !clr) begin
            mem_idx[count[AW-1:0]] <= wr_index;
            mem_ts[count[AW-1:0]]  <= wr_time;
        end
    end

    assign rd_index = mem_idx[rd_addr];
    assign rd_time  = mem_ts[rd_addr];

    assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    assert_ovf_when_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> count == CW'(DEPTH));

endmodule

// File: rtl/tsfreq_regress.sv
// Top level: timestamps each synchronized rising edge of sig_in while the gate
// is open, streams and buffers the records, and accumulates the regression
// sums. done pulses the cycle after the gate closes.
// Assumes gate is synchronous to clk and a gate lasts fewer than 2**TS_W cycles.
module tsfreq_regress
    import tsr_pkg::*;
#(
    parameter int TS_W        = 16,
    parameter int DEPTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sig_in,
    input  logic                       gate,
    input  logic [$clog2(DEPTH)-1:0]   rd_addr,
    output logic                       cap_valid,
    output logic [TS_W-1:0]            cap_index,
    output logic [TS_W-1:0]            cap_time,
    output logic [TS_W-1:0]            rd_index,
    output logic [TS_W-1:0]            rd_time,
    output logic [$clog2(DEPTH+1)-1:0] buf_count,
    output logic                       overflow,
    output logic                       done,
    output logic [TS_W-1:0]            sum_n,
    output logic [2*TS_W-1:0]          sum_x,
    output logic [2*TS_W-1:0]          sum_y,
    output logic [3*TS_W-1:0]          sum_xy,
    output logic [3*TS_W-1:0]          sum_xx
);
    gate_ctl_t       ctl;
    logic [TS_W-1:0] tcount;
    logic [TS_W-1:0] event_idx;
    logic            rise, capture;

    tsr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(sig_in), .rise(rise));

    tsr_timebase #(.TS_W(TS_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .gate(gate), .ctl(ctl), .tcount(tcount));

    assign capture = rise & ctl.open;

    // Running event number, restarted with each gate.
    always_ff @(posedge clk) begin
        if (!rst_n || ctl.start) event_idx <= '0;
        else if (capture)        event_idx <= event_idx + 1'b1;
    end

    // Capture stream register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_valid <= 1'b0;
            cap_index <= '0;
            cap_time  <= '0;
        end else begin
            cap_valid <= capture;
            if (capture) begin
                cap_index <= event_idx;
                cap_time  <= tcount;
            end
        end
    end

    // End-of-gate pulse; the last capture lands in the sums on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= ctl.stop;
    end

    tsr_accum #(.TS_W(TS_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr(ctl.start), .add(capture),
        .x(event_idx), .y(tcount),
        .s_n(sum_n), .s_x(sum_x), .s_y(sum_y), .s_xy(sum_xy), .s_xx(sum_xx));

    tsr_capbuf #(.TS_W(TS_W), .DEPTH(DEPTH)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(ctl.start), .wr(capture),
        .wr_index(event_idx), .wr_time(tcount), .rd_addr(rd_addr),
        .rd_index(rd_index), .rd_time(rd_time),
        .count(buf_count), .ovf(overflow));

    assert_strobe_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |=> !cap_valid);

    assert_count_matches_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |-> sum_n == cap_index + 1'b1);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/tsfreq_regress_test.sv
// Gate-by-gate sweep with arithmetic reference values for timestamps, sums
// and buffer contents.
module tsfreq_regress_test;
    localparam int TS_W  = 16;
    localparam int DEPTH = 8;
    localparam int AW    = 3;
    localparam int CW    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sig_in = 1'b0;
    logic gate = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic cap_valid, overflow, done;
    logic [TS_W-1:0] cap_index, cap_time, rd_index, rd_time, sum_n;
    logic [CW-1:0] buf_count;
    logic [2*TS_W-1:0] sum_x, sum_y;
    logic [3*TS_W-1:0] sum_xy, sum_xx;

    tsfreq_regress #(.TS_W(TS_W), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .gate(gate),
        .rd_addr(rd_addr), .cap_valid(cap_valid), .cap_index(cap_index),
        .cap_time(cap_time), .rd_index(rd_index), .rd_time(rd_time),
        .buf_count(buf_count), .overflow(overflow), .done(done),
        .sum_n(sum_n), .sum_x(sum_x), .sum_y(sum_y),
        .sum_xy(sum_xy), .sum_xx(sum_xx));

    always #10 clk = ~clk;

    int edge_no = 0;
    always @(posedge clk) edge_no <= edge_no + 1;

    int n_chk = 0, n_bad = 0;
    longint exp_ts [0:255];
    int exp_n = 0, g_edge = 0, mon_idx = 0;
    bit finished = 1'b0;

    task automatic chk(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Capture stream monitor (R3 timestamp, R4 index)
    always @(negedge clk) begin
        if (cap_valid) begin
            chk("R3 cap_time", cap_time, exp_ts[mon_idx & 255]);
            chk("R4 cap_index", cap_index, mon_idx);
            mon_idx++;
        end
    end

    task automatic open_gate();
        gate = 1'b1;
        g_edge = edge_no + 1;
        exp_n = 0;
        mon_idx = 0;
        @(negedge clk);
    endtask

    task automatic pulse(int hi, int lo, bit counted);
        sig_in = 1'b1;
        if (counted) begin
            exp_ts[exp_n] = longint'(edge_no + 1 - g_edge + 1);
            exp_n++;
        end
        repeat (hi) @(negedge clk);
        sig_in = 1'b0;
        repeat (lo) @(negedge clk);
    endtask

    task automatic close_and_check();
        longint sn, sx, sy, sxy, sxx;
        int kept;
        repeat (3) @(negedge clk);
        gate = 1'b0;
        @(negedge clk);
        chk("R8 done after close", done, 1);
        sn = 0; sx = 0; sy = 0; sxy = 0; sxx = 0;
        for (int k = 0; k < exp_n; k++) begin
            sn++; sx += k; sy += exp_ts[k];
            sxy += k * exp_ts[k]; sxx += k * k;
        end
        chk("R5 sum_n", sum_n, sn);
        chk("R5 sum_x", sum_x, sx);
        chk("R5 sum_y", sum_y, sy);
        chk("R5 sum_xy", sum_xy, sxy);
        chk("R5 sum_xx", sum_xx, sxx);
        chk("R2 one capture per edge", mon_idx, exp_n);
        kept = (exp_n > DEPTH) ? DEPTH : exp_n;
        chk("R9 buf_count", buf_count, kept);
        chk("R10 overflow flag", overflow, (exp_n > DEPTH) ? 1 : 0);
        for (int k = 0; k < kept; k++) begin
            rd_addr = AW'(k);
            #1;
            chk("R9 rd_index", rd_index, k);
            chk("R9 rd_time", rd_time, exp_ts[k]);
        end
        @(negedge clk);
        chk("R8 done single cycle", done, 0);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 cap_valid", cap_valid, 0);
        chk("R1 cap_index", cap_index, 0);
        chk("R1 cap_time", cap_time, 0);
        chk("R1 buf_count", buf_count, 0);
        chk("R1 overflow", overflow, 0);
        chk("R1 done", done, 0);
        chk("R1 sums", sum_n + sum_x + sum_y + sum_xy + sum_xx, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Main sweep: pulse counts 2..11, varied widths, overflow past DEPTH
        for (int g = 0; g < 10; g++) begin
            open_gate();
            // R6 clear on gate start (after a possibly overflowed gate)
            chk("R6 sum_n cleared", sum_n, 0);
            chk("R6 buf_count cleared", buf_count, 0);
            chk("R6 overflow cleared", overflow, 0);
            if (g % 3 != 0) repeat (g) @(negedge clk);
            for (int k = 0; k < g + 2; k++)
                pulse(1 + (k % 3), 1 + ((k * g + 1) % 5), 1'b1);
            close_and_check();
        end

        // R2 held-high input counts once
        open_gate();
        pulse(12, 2, 1'b1);
        pulse(1, 1, 1'b1);
        close_and_check();

        // R7 edges with gate closed are ignored
        for (int k = 0; k < 3; k++) pulse(2, 2, 1'b0);
        repeat (3) @(negedge clk);
        chk("R7 no capture while closed", mon_idx, 2);
        chk("R7 sum_n unchanged", sum_n, 2);
        chk("R7 sum_y unchanged", sum_y, exp_ts[0] + exp_ts[1]);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule